// File: doc/BRIEF.md
# Sector-Based External Memory Wait-State Controller

This block drives read and write strobes for an 8-bit external parallel memory on a 16-bit address space. It stretches each strobe by a programmable number of wait cycles. External memory occupies addresses 0x1100 through 0xFFFF. A 3-bit boundary code can cut this space into a lower and an upper sector, and each sector has its own 2-bit wait code. The wait setting for an access is therefore picked by address, against a boundary that software can move, and is not one fixed count for the whole bus.

A CPU-side request channel uses a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the requester must hold its address, direction and write data steady until that edge. The response channel has no back-pressure. `rsp_valid` is a one-cycle pulse that the requester must take when it comes, and `rsp_rdata` is valid with it for reads.

A request to an address below 0x1100 is accepted but dropped: the external bus does nothing and no response follows. An 8-bit configuration port holds the boundary and both wait codes, and its contents can be read back.

Top module: `ext_wait_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, `req_ready` is 1, and `bus_rd`, `bus_wr` and `rsp_valid` are 0.
- R2: The configuration byte has three fields: bits [6:4] are the boundary code, bits [3:2] are the lower-sector wait code and bits [1:0] are the upper-sector wait code. A write with `cfg_we` high updates the byte at the next edge. Bit 7 always reads 0, and anything written to it is ignored.
- R3: A request accepted with an address below 0x1100 produces no strobe and no `rsp_valid`. The external bus never shows a strobe for such an address.
- R4: An accepted external access asserts exactly one strobe for 1 + E consecutive cycles. The strobe is `bus_rd` for a read or `bus_wr` for a write. E depends on the selected wait code: code 0 gives E=0, code 1 gives E=1, code 2 gives E=2 and code 3 gives E=2.
- R5: With wait code 3, one more cycle follows the strobe. In that cycle no strobe is asserted and `req_ready` stays 0.
- R6: With boundary code 0, every external access uses the upper-sector wait code.
- R7: With boundary code n from 1 to 7, an address at or above n×0x2000 uses the upper-sector wait code. An address from 0x1100 up to one below that boundary uses the lower-sector wait code.
- R8: The sector and wait code are decided from the configuration that was in force before the accepting edge. A configuration write on that same edge, or during the access, affects only later accesses.
- R9: `rsp_valid` pulses high for exactly one cycle, in the cycle right after the last strobe cycle. For a read, `rsp_rdata` then holds the value `bus_rdata` had in the last strobe cycle.
- R10: While a strobe is active, `bus_addr` equals the accepted request address and stays stable. During a write strobe, `bus_wdata` equals the accepted write data. `bus_rd` and `bus_wr` are never high together.
- R11: `req_ready` is 1 only when the controller is idle. It is 0 in every strobe cycle and in every recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read-back |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid on reads |
| bus_addr | output | 16 | External address |
| bus_wdata | output | 8 | External write data |
| bus_rdata | input | 8 | External read data |
| bus_rd | output | 1 | External read strobe, active high |
| bus_wr | output | 1 | External write strobe, active high |

## Verification
The assertions cover the properties that hold on every cycle whatever the configuration:
- the strobes are never high together, and the address is stable while a strobe is active;
- strobes appear only for external addresses, and no strobe run exceeds three cycles;
- the response pulse lasts one cycle and comes right after a strobe;
- `req_ready` is low while the bus is busy;
- the configuration holds when it is not written.

Only the bench scenarios can show the following:
- that the correct sector and wait code are chosen on either side of every boundary;
- that a configuration write on the accepting edge is deferred;
- that the recovery cycle follows code 3;
- that captured read data matches the last strobe cycle.

// File: rtl/ewc_pkg.sv
`timescale 1ns/1ps
package ewc_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int CFG_W   = 8;
  localparam int LIMIT_W = 3;
  localparam int WS_W    = 2;
  localparam logic [ADDR_W-1:0] EXT_BASE = 16'h1100;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RECOVER = 2'd2
  } ewc_state_e;
endpackage

// File: rtl/ewc_cfg_reg.sv
`timescale 1ns/1ps
module ewc_cfg_reg
  import ewc_pkg::*;
#(
  parameter int P_CFG_W   = CFG_W,
  parameter int P_LIMIT_W = LIMIT_W,
  parameter int P_WS_W    = WS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [P_CFG_W-1:0]   cfg_wdata,
  output logic [P_CFG_W-1:0]   cfg_rdata,
  output logic [P_LIMIT_W-1:0] limit,
  output logic [P_WS_W-1:0]    ws_lo,
  output logic [P_WS_W-1:0]    ws_hi
);
  localparam int USED_W = P_LIMIT_W + 2*P_WS_W;
  localparam int PAD_W  = P_CFG_W - USED_W;

  logic [USED_W-1:0] cfg_q;

  // Only the defined fields are stored; reserved bits have no flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[USED_W-1:0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign cfg_rdata = {{PAD_W{1'b0}}, cfg_q};
    end else begin : g_nopad
      assign cfg_rdata = cfg_q;
    end
  endgenerate

  assign limit = cfg_q[USED_W-1 -: P_LIMIT_W];
  assign ws_lo = cfg_q[2*P_WS_W-1 -: P_WS_W];
  assign ws_hi = cfg_q[P_WS_W-1:0];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata)); // R2

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[USED_W-1:0] == $past(cfg_wdata[USED_W-1:0])); // R2
endmodule

// File: rtl/ewc_sector_decode.sv
`timescale 1ns/1ps
module ewc_sector_decode
  import ewc_pkg::*;
#(
  parameter int                  P_ADDR_W   = ADDR_W,
  parameter int                  P_LIMIT_W  = LIMIT_W,
  parameter int                  P_WS_W     = WS_W,
  parameter logic [P_ADDR_W-1:0] P_EXT_BASE = EXT_BASE
) (
  input  logic [P_ADDR_W-1:0]  addr,
  input  logic [P_LIMIT_W-1:0] limit,
  input  logic [P_WS_W-1:0]    ws_lo,
  input  logic [P_WS_W-1:0]    ws_hi,
  output logic                 is_ext,
  output logic                 in_upper,
  output logic [P_WS_W-1:0]    ws_sel
);
  localparam int LOW_W = P_ADDR_W - P_LIMIT_W;

  logic [P_ADDR_W-1:0] boundary;

  // Boundary code n places the upper sector at n * 2^LOW_W; code 0 yields 0,
  // so every address compares as upper and the lower sector vanishes.
  assign boundary = {limit, {LOW_W{1'b0}}};
  assign is_ext   = (addr >= P_EXT_BASE);
  assign in_upper = (addr >= boundary);
  assign ws_sel   = in_upper ? ws_hi : ws_lo;
endmodule

// File: rtl/ewc_strobe_seq.sv
`timescale 1ns/1ps
module ewc_strobe_seq
  import ewc_pkg::*;
#(
  parameter int                  P_ADDR_W   = ADDR_W,
  parameter int                  P_DATA_W   = DATA_W,
  parameter int                  P_WS_W     = WS_W,
  parameter logic [P_ADDR_W-1:0] P_EXT_BASE = EXT_BASE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [P_ADDR_W-1:0] req_addr,
  input  logic                req_write,
  input  logic [P_DATA_W-1:0] req_wdata,
  input  logic                is_ext,
  input  logic [P_WS_W-1:0]   ws_sel,
  output logic                req_ready,
  output logic [P_ADDR_W-1:0] bus_addr,
  output logic [P_DATA_W-1:0] bus_wdata,
  input  logic [P_DATA_W-1:0] bus_rdata,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic                rsp_valid,
  output logic [P_DATA_W-1:0] rsp_rdata
);
  localparam logic [P_WS_W-1:0] WS_MAX = '1;
  localparam int                RUN_W  = P_WS_W + 2;

  ewc_state_e          state;
  logic [P_WS_W-1:0]   cnt;
  logic                wr_q, rec_q, rsp_q;
  logic [P_ADDR_W-1:0] addr_q;
  logic [P_DATA_W-1:0] wdata_q, rdata_q;
  logic [P_WS_W-1:0]   extra;
  logic                recover;
  logic                strobe;

  // The top code keeps the longest strobe and adds one recovery cycle.
  always_comb begin
    recover = (ws_sel == WS_MAX);
    extra   = recover ? (WS_MAX - 1'b1) : ws_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      rec_q   <= 1'b0;
      rsp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && is_ext) begin
            state   <= ST_STROBE;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            cnt     <= extra;
            rec_q   <= recover;
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            rsp_q <= 1'b1;
            if (!wr_q) rdata_q <= bus_rdata;
            state <= rec_q ? ST_RECOVER : ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOVER: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign strobe    = (state == ST_STROBE);
  assign bus_rd    = strobe && !wr_q;
  assign bus_wr    = strobe && wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // Checker: length of the current strobe run.
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len <= '0;
    else if (bus_rd || bus_wr)    run_len <= run_len + 1'b1;
    else                          run_len <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && $past(bus_rd || bus_wr) |-> $stable(bus_addr)); // R10
  AST_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_addr >= P_EXT_BASE); // R3
  AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> run_len < RUN_W'(WS_MAX)); // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_rd || bus_wr)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !req_ready); // R11
endmodule

// File: rtl/ext_wait_ctrl.sv
`timescale 1ns/1ps
module ext_wait_ctrl
  import ewc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr
);
  logic [LIMIT_W-1:0] limit;
  logic [WS_W-1:0]    ws_lo, ws_hi, ws_sel;
  logic               is_ext, in_upper;

  ewc_cfg_reg #(
    .P_CFG_W(CFG_W), .P_LIMIT_W(LIMIT_W), .P_WS_W(WS_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .limit(limit), .ws_lo(ws_lo), .ws_hi(ws_hi)
  );

  ewc_sector_decode #(
    .P_ADDR_W(ADDR_W), .P_LIMIT_W(LIMIT_W), .P_WS_W(WS_W), .P_EXT_BASE(EXT_BASE)
  ) u_dec (
    .addr(req_addr), .limit(limit), .ws_lo(ws_lo), .ws_hi(ws_hi),
    .is_ext(is_ext), .in_upper(in_upper), .ws_sel(ws_sel)
  );

  ewc_strobe_seq #(
    .P_ADDR_W(ADDR_W), .P_DATA_W(DATA_W), .P_WS_W(WS_W), .P_EXT_BASE(EXT_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .is_ext(is_ext),
    .ws_sel(ws_sel), .req_ready(req_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  AST_SECTOR_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> (in_upper && ws_sel == ws_hi)); // R6
endmodule

// File: tb/tb_ext_wait_ctrl.sv
`timescale 1ns/1ps
module tb_ext_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_rd, bus_wr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr)
  );

  // Changing read data every cycle exposes the capture cycle.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    bus_rdata <= 8'((cyc * 37) + 5);
  end

  // Behavioural reference: m_phase 0 idle, 1 strobing, 2 recovery.
  int   m_phase = 0, m_left = 0, m_cfg = 0;
  bit   m_rec = 0, m_wr = 0, m_rsp = 0;
  int   m_addr = 0, m_wdata = 0, m_rdata = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_cfg = 0; m_rec = 0; m_wr = 0; m_rsp = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else begin
      int lim, code;
      m_rsp = 0;
      if (m_phase == 0) begin
        if (req_valid && int'(req_addr) >= 'h1100) begin
          lim  = (m_cfg >> 4) & 7;
          code = (int'(req_addr) >= lim * 'h2000) ? (m_cfg & 3) : ((m_cfg >> 2) & 3);
          m_left  = (code == 3) ? 2 : code;
          m_rec   = (code == 3);
          m_addr  = int'(req_addr);
          m_wr    = req_write;
          m_wdata = int'(req_wdata);
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (m_left == 0) begin
          m_rsp = 1;
          if (!m_wr) m_rdata = int'(bus_rdata);
          m_phase = m_rec ? 2 : 0;
        end else m_left = m_left - 1;
      end else m_phase = 0;
      if (cfg_we) m_cfg = int'(cfg_wdata) & 'h7F;
    end
  end

  task automatic bad(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      tests++;
      if (int'(cfg_rdata) != m_cfg) bad("R2", "cfg_rdata", int'(cfg_rdata), m_cfg);
      if (req_ready != (m_phase == 0)) bad("R11", "req_ready", int'(req_ready), int'(m_phase == 0));
      if (bus_rd != (m_phase == 1 && !m_wr)) bad("R4", "bus_rd", int'(bus_rd), int'(m_phase == 1 && !m_wr));
      if (bus_wr != (m_phase == 1 && m_wr)) bad("R4", "bus_wr", int'(bus_wr), int'(m_phase == 1 && m_wr));
      if (m_phase == 1 && int'(bus_addr) != m_addr) bad("R10", "bus_addr", int'(bus_addr), m_addr);
      if (m_phase == 1 && m_wr && int'(bus_wdata) != m_wdata) bad("R10", "bus_wdata", int'(bus_wdata), m_wdata);
      if (rsp_valid != m_rsp) bad("R9", "rsp_valid", int'(rsp_valid), int'(m_rsp));
      if (m_rsp && !m_wr && int'(rsp_rdata) != m_rdata) bad("R9", "rsp_rdata", int'(rsp_rdata), m_rdata);
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic w, input logic [7:0] d,
                        input logic cw, input logic [7:0] cd,
                        output int slen, output int busy, output int nrsp);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    cfg_we = cw; cfg_wdata = cd;
    slen = 0; busy = 0; nrsp = 0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (bus_rd || bus_wr) slen++;
      if (!req_ready) busy++;
      if (rsp_valid) nrsp++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    done = 1;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s, b, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cfg_rdata", int'(cfg_rdata), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 strobes", int'(bus_rd) + int'(bus_wr), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;

    access(16'h2000, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R4 code0 strobe", s, 1);
    chk("R9 one rsp", n, 1);

    wcfg(8'hFF);
    @(negedge clk);
    chk("R2 reserved bit reads 0", int'(cfg_rdata), 'h7F);

    wcfg(8'h06); // boundary 0, lower 01, upper 10
    access(16'h1100, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R6 boundary0 uses upper", s, 3);

    wcfg(8'h14); // boundary 1, lower 01, upper 00
    access(16'h1FFF, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R7 below 0x2000 lower", s, 2);
    access(16'h2000, 1'b1, 8'hA5, 1'b0, 8'h00, s, b, n);
    chk("R7 at 0x2000 upper", s, 1);

    wcfg(8'h4B); // boundary 4, lower 10, upper 11
    access(16'h7FFF, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R7 below 0x8000 lower", s, 3);
    chk("R5 code2 no recovery", b, 3);
    access(16'h8000, 1'b1, 8'h3C, 1'b0, 8'h00, s, b, n);
    chk("R4 code3 strobe", s, 3);
    chk("R5 code3 recovery busy", b, 4);

    wcfg(8'h71); // boundary 7, lower 00, upper 01
    access(16'hDFFF, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R7 below 0xE000 lower", s, 1);
    access(16'hE000, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R7 at 0xE000 upper", s, 2);

    access(16'h10FF, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R3 low addr no strobe", s, 0);
    chk("R3 low addr no rsp", n, 0);
    access(16'h0000, 1'b1, 8'h11, 1'b0, 8'h00, s, b, n);
    chk("R3 zero addr no strobe", s + n, 0);

    wcfg(8'h00);
    access(16'h3000, 1'b0, 8'h00, 1'b1, 8'h02, s, b, n);
    chk("R8 same-edge cfg deferred", s, 1);
    access(16'h3000, 1'b0, 8'h00, 1'b0, 8'h00, s, b, n);
    chk("R8 cfg applied next access", s, 3);

    // Back-to-back mixed traffic, checked by the per-cycle model (R9 R10 R11).
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (req_ready) begin
        req_valid = ($urandom % 4) != 0;
        req_addr  = (($urandom % 8) == 0) ? 16'($urandom % 'h1100) : 16'($urandom);
        req_write = $urandom % 2;
        req_wdata = 8'($urandom);
      end
      cfg_we    = ($urandom % 16) == 0;
      cfg_wdata = 8'($urandom);
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    repeat (8) @(negedge clk);
    done = 1;
    summary();
  end
endmodule